// File: doc/BRIEF.md
# Bit-Serial Microsequencer Timing Unit

This block supplies the timing backbone of a bit-serial processor. A divider turns the fast master clock into a single-cycle bit-clock enable. That enable fires only while the run input is high. Every other part of the machine advances on the enable. A bit counter steps through the 18 bit times of one serial word, and its value serves as the low-order address for main memory and for the register storage memories.

One microinstruction occupies a whole word time. When the last bit time of a word ends, a 4-bit state counter moves to the next step. It either increments or, when a microbranch is requested, loads a branch target. The microcode ROM address is the current opcode with the state number appended below it. An end-of-word strobe marks the final bit time, so that neighbouring blocks can commit word-level results.

Top module: `useq_timing`

## Requirements
- R1: While rst_ni is low, and directly after it rises, bit_cnt_o and state_o are 0 and bit_en_o is 0; the divider restarts from zero.
- R2: While run_i stays high, bit_en_o is high for exactly one master cycle in every DIV_N cycles. The first pulse after reset comes in the DIV_N-th cycle with run_i high.
- R3: While run_i is low, bit_en_o is 0 and the divider, the bit counter and the state counter all keep their values; counting resumes where it stopped.
- R4: bit_cnt_o advances by one on each master edge that has bit_en_o high, counts 0 to WORD_BITS-1 (17 by default) and then wraps to 0. It never changes otherwise.
- R5: eow_o is high exactly while bit_cnt_o equals WORD_BITS-1.
- R6: On an edge with bit_en_o high and bit_cnt_o at WORD_BITS-1 and br_take_i low, state_o increments by one, wrapping from 15 to 0.
- R7: On an edge with bit_en_o high and bit_cnt_o at WORD_BITS-1 and br_take_i high, state_o loads br_target_i.
- R8: On every other edge, state_o does not change, whatever br_take_i and br_target_i hold.
- R9: uaddr_o equals {opcode_i, state_o}, with the opcode in bits [OP_W+3:4] and the state in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable; low freezes all timing |
| opcode_i | input | OP_W | Opcode of the current machine instruction |
| br_take_i | input | 1 | Microbranch request, used only at the word boundary |
| br_target_i | input | 4 | Microbranch target state |
| bit_en_o | output | 1 | Bit-clock enable, one master cycle wide |
| bit_cnt_o | output | $clog2(WORD_BITS) | Bit time within the serial word |
| eow_o | output | 1 | High during the last bit time of a word |
| state_o | output | 4 | Microinstruction step number |
| uaddr_o | output | OP_W+4 | Microcode ROM address |

## Verification
The hardest case to reach is a word boundary that meets a stop. This happens when run_i falls while the bit counter sits at 17, perhaps one cycle before the enable would fire. A branch request must then wait through the stall and take effect only on the enable that finally arrives. The bench uses a small divider ratio and a pseudo-random run pattern over several thousand cycles, so stops land at every divider phase and every bit time. Branch requests and targets change on every cycle, so most requests fall off the boundary and must be ignored. A second phase holds run high and sweeps the branch target through all 16 values at boundaries that are known to occur.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int unsigned STATE_W = 4;
  typedef logic [STATE_W-1:0] state_t;
  typedef struct packed {
    logic   take;
    state_t target;
  } ubranch_t;
endpackage

// File: rtl/useq_divider.sv
module useq_divider #(
  parameter int unsigned DIV_N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_N - 1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R3
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  // R2
  tick_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
  generate
    if (DIV_N > 1) begin : g_spacing
      // R2
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/useq_bitctr.sv
module useq_bitctr #(
  parameter int unsigned WORD_BITS = 18,
  localparam int unsigned BIT_W = $clog2(WORD_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [BIT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_BITS - 1);

  logic [BIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  // R4
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4
  bit_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (cnt_q == LAST) |=> cnt_q == '0);
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/useq_statectr.sv
module useq_statectr
  import useq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  input  ubranch_t br_i,
  output state_t   state_o
);
  state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= '0;
    else if (step_i)     state_q <= br_i.take ? br_i.target : state_q + 1'b1;
  end

  assign state_o = state_q;

  // R8
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
  // R6
  state_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !br_i.take |=> state_q == STATE_W'($past(state_q) + 1'b1));
  // R7
  state_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_i.take |=> state_q == $past(br_i.target));
endmodule

// File: rtl/useq_timing.sv
module useq_timing
  import useq_pkg::*;
#(
  parameter int unsigned DIV_N     = 16,
  parameter int unsigned WORD_BITS = 18,
  parameter int unsigned OP_W      = 5,
  localparam int unsigned BIT_W    = $clog2(WORD_BITS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [OP_W-1:0]         opcode_i,
  input  logic                    br_take_i,
  input  logic [STATE_W-1:0]      br_target_i,
  output logic                    bit_en_o,
  output logic [BIT_W-1:0]        bit_cnt_o,
  output logic                    eow_o,
  output logic [STATE_W-1:0]      state_o,
  output logic [OP_W+STATE_W-1:0] uaddr_o
);
  logic     tick;
  logic     last_bit;
  ubranch_t br;
  state_t   state;

  assign br = '{take: br_take_i, target: br_target_i};

  useq_divider #(.DIV_N(DIV_N)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_o(tick)
  );

  useq_bitctr #(.WORD_BITS(WORD_BITS)) u_bit (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tick),
    .cnt_o (bit_cnt_o), .last_o(last_bit)
  );

  // word boundary: last bit time ending on an enable
  useq_statectr u_state (
    .clk_i (clk_i), .rst_ni(rst_ni), .step_i(tick && last_bit),
    .br_i  (br), .state_o(state)
  );

  assign bit_en_o = tick;
  assign eow_o    = last_bit;
  assign state_o  = state;
  assign uaddr_o  = {opcode_i, state};

  // R5
  eow_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_o |-> bit_cnt_o == BIT_W'(WORD_BITS - 1));
  // R8
  state_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_o != BIT_W'(WORD_BITS - 1)) |=> $stable(state_o));
  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(bit_cnt_o) && $stable(state_o));
endmodule

// File: tb/useq_timing_tb_top.sv
module useq_timing_tb_top;
  localparam int DIV_N = 3;
  localparam int WB    = 18;
  localparam int OP_W  = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [4:0]  opcode_i = '0;
  logic        br_take_i = 1'b0;
  logic [3:0]  br_target_i = '0;
  logic        bit_en_o;
  logic [4:0]  bit_cnt_o;
  logic        eow_o;
  logic [3:0]  state_o;
  logic [8:0]  uaddr_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  useq_timing #(.DIV_N(DIV_N), .WORD_BITS(WB), .OP_W(OP_W)) dut_i (
    .clk_i, .rst_ni, .run_i, .opcode_i, .br_take_i, .br_target_i,
    .bit_en_o, .bit_cnt_o, .eow_o, .state_o, .uaddr_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  int e_div, e_bit, e_state, e_ben;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    e_div = 0; e_bit = 0; e_state = 0;
    #1;
    // R1 during reset
    chk("R1 bit_cnt in reset", bit_cnt_o, 0);
    chk("R1 state in reset", state_o, 0);
    chk("R1 bit_en in reset", bit_en_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c < 3000) begin
        run_i       = (lfsr[1:0] != 2'b00);
        br_take_i   = lfsr[5];
        br_target_i = lfsr[9:6];
      end else begin
        run_i       = 1'b1;
        br_take_i   = ((c / (DIV_N * WB)) % 2) == 0;
        br_target_i = 4'((c / (2 * DIV_N * WB)) % 16);
        if (!br_take_i) br_target_i = lfsr[9:6];
      end
      opcode_i = lfsr[14:10];
      #1;
      e_ben = (run_i && e_div == DIV_N - 1) ? 1 : 0;
      if (c == 0) chk("R1 after release", bit_cnt_o + state_o, 0);
      chk(run_i ? "R2 bit_en" : "R3 bit_en stopped", bit_en_o, e_ben);
      chk(run_i ? "R4 bit_cnt" : "R3 bit_cnt hold", bit_cnt_o, e_bit);
      chk("R5 eow", eow_o, (e_bit == WB - 1) ? 1 : 0);
      chk((e_bit == WB - 1) ? (br_take_i ? "R7 state" : "R6 state") : "R8 state",
          state_o, e_state);
      chk("R9 uaddr", uaddr_o, (int'(opcode_i) << 4) | e_state);
      // next-state model
      if (run_i) e_div = (e_div == DIV_N - 1) ? 0 : e_div + 1;
      if (e_ben == 1) begin
        if (e_bit == WB - 1) begin
          e_state = br_take_i ? int'(br_target_i) : (e_state + 1) % 16;
          e_bit = 0;
        end else e_bit = e_bit + 1;
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule